// File: doc/BRIEF.md
# Scintillator-Confirmed Wire Centroid Finder

This block serves one chamber layer of a muon trigger. Each crossing it receives the hit bits of 96 drift wires together with the hit bits of the scintillator counters that cover the same area. A wire hit survives only if a scintillator counter over it, or a counter directly beside that one, also fired. The surviving wires are then grouped into runs of adjacent wires. Each run is reported as one centroid bit on a grid of half a wire cell, so the 96 wires give a 192-bit centroid map. In the same cycle the block reports how many scintillator counters fired, as a 2-bit count that stops at three.

The inner and outer layers are paired with a 48-counter scintillator plane. The middle layer borrows the 96-counter outer scintillator plane. The parameter `N_SCINT` selects between these two cases. Every result is registered and appears one clock after the strobe that qualified the inputs.

Top module: `scint_wire_centroid`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `centroid` and `scint_count` to zero on the next rising edge. Reset takes priority over an input strobe in the same cycle.
- R2: When `in_valid` is high at a rising edge, `out_valid` is high after that edge, and `centroid` and `scint_count` show the result for the inputs sampled at that edge. Otherwise `out_valid` is low after the edge.
- R3: While `in_valid` is low, `centroid` and `scint_count` keep their previous values, whatever the wire and scintillator inputs do.
- R4: Wire i is confirmed when it is hit and at least one of these counters is hit: counter s = floor(i*N_SCINT/96), counter s-1, or counter s+1. Only counters inside 0..N_SCINT-1 are considered. A hit wire that is not confirmed sets no centroid bit.
- R5: A confirmed wire i whose neighbours are both unconfirmed sets centroid bit 2i.
- R6: Two adjacent confirmed wires i and i+1, bounded by unconfirmed wires, set only centroid bit 2i+1.
- R7: A run of three or more confirmed wires from a to b sets only centroid bit a+b, which is the run's midpoint in half-cell units.
- R8: Runs are formed from confirmed wires only. A hit but unconfirmed wire inside a row of hit wires splits the row into separate runs, and each run gets its own centroid bit.
- R9: Wires 0 and 95 and scintillator counters 0 and N_SCINT-1 are handled without wrap-around. A run touching either end of the layer is closed at that end.
- R10: `scint_count` equals the number of set scintillator bits, capped at 3.
- R11: With N_SCINT = 96 (the middle-layer case), wire i is confirmed by counters i-1, i or i+1, following the same rule as R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the hit inputs at this edge |
| wire_hits | input | N_WIRE (96) | Drift-wire hit bits, bit i = wire i |
| scint_hits | input | N_SCINT (48) | Scintillator counter hit bits |
| out_valid | output | 1 | Results below are new this cycle |
| centroid | output | 2*N_WIRE (192) | Half-cell centroid map |
| scint_count | output | CNT_W (2) | Saturating count of hit counters |

## Verification
Every result is due one rising edge after the edge that sampled `in_valid`. The bench drives inputs on a falling edge, raises the strobe for exactly one cycle, and compares `out_valid`, `centroid` and `scint_count` on the next falling edge. At that point the only register stage has loaded. One cycle later, with the strobe low and every input inverted, it checks that the outputs have held. Two instances run side by side, one with 48 counters and one with 96. They are swept over single wires, adjacent pairs, runs at the layer edges, and every counter offset around each wire, followed by random patterns.

// File: rtl/swc_pkg.sv
package swc_pkg;

  // Nominal scintillator counter lying over a given wire.
  function automatic int nominal_counter(input int wire_idx, input int n_wire, input int n_scint);
    return (wire_idx * n_scint) / n_wire;
  endfunction

  // Lowest counter index accepted for a wire (one below nominal, clipped).
  function automatic int window_lo(input int wire_idx, input int n_wire, input int n_scint);
    int s;
    s = nominal_counter(wire_idx, n_wire, n_scint);
    return (s > 0) ? s - 1 : 0;
  endfunction

  // Highest counter index accepted for a wire (one above nominal, clipped).
  function automatic int window_hi(input int wire_idx, input int n_wire, input int n_scint);
    int s;
    s = nominal_counter(wire_idx, n_wire, n_scint);
    return (s < n_scint - 1) ? s + 1 : n_scint - 1;
  endfunction

endpackage

// File: rtl/swc_confirm.sv
module swc_confirm
  import swc_pkg::*;
#(
  parameter int N_WIRE  = 96,
  parameter int N_SCINT = 48
) (
  input  logic [N_WIRE-1:0]  wire_hits,
  input  logic [N_SCINT-1:0] scint_hits,
  output logic [N_WIRE-1:0]  confirmed
);

  // One AND of the wire hit with a small OR window of counters per wire.
  for (genvar g = 0; g < N_WIRE; g++) begin : g_wire
    localparam int LO = window_lo(g, N_WIRE, N_SCINT);
    localparam int HI = window_hi(g, N_WIRE, N_SCINT);
    assign confirmed[g] = wire_hits[g] & (|scint_hits[HI:LO]);
  end

endmodule

// File: rtl/swc_centroid.sv
module swc_centroid #(
  parameter int N_WIRE = 96
) (
  input  logic [N_WIRE-1:0]   confirmed,
  output logic [2*N_WIRE-1:0] centroid
);

  localparam int OUT_W = 2 * N_WIRE;
  localparam int IW    = $clog2(N_WIRE);
  localparam int OIW   = $clog2(OUT_W);

  // Walk the layer once, remembering where the current run began. When a
  // run closes at wire b, the half-cell index start+b marks its midpoint.
  always_comb begin
    logic [IW-1:0]  run_start;
    logic           in_run;
    logic [OIW-1:0] pos;
    centroid  = '0;
    run_start = '0;
    in_run    = 1'b0;
    pos       = '0;
    for (int i = 0; i < N_WIRE; i++) begin
      if (confirmed[i] && !in_run) begin
        run_start = IW'(i);
      end
      if (!confirmed[i] && in_run) begin
        pos = OIW'(run_start) + OIW'(i) - OIW'(1);
        centroid[pos] = 1'b1;
      end
      in_run = confirmed[i];
    end
    if (in_run) begin
      pos = OIW'(run_start) + OIW'(N_WIRE - 1);
      centroid[pos] = 1'b1;
    end
  end

endmodule

// File: rtl/swc_scint_count.sv
module swc_scint_count #(
  parameter int N_SCINT = 48,
  parameter int CNT_W   = 2
) (
  input  logic [N_SCINT-1:0] scint_hits,
  output logic [CNT_W-1:0]   count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Saturating tally: once full, further hits are absorbed.
  always_comb begin
    count = '0;
    for (int i = 0; i < N_SCINT; i++) begin
      if (scint_hits[i] && count != CNT_MAX) begin
        count = count + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/scint_wire_centroid.sv
module scint_wire_centroid #(
  parameter int N_WIRE  = 96,
  parameter int N_SCINT = 48,
  parameter int CNT_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [N_WIRE-1:0]     wire_hits,
  input  logic [N_SCINT-1:0]    scint_hits,
  output logic                  out_valid,
  output logic [2*N_WIRE-1:0]   centroid,
  output logic [CNT_W-1:0]      scint_count
);

  localparam int OUT_W = 2 * N_WIRE;

  logic [N_WIRE-1:0] confirmed;
  logic [OUT_W-1:0]  centroid_d;
  logic [CNT_W-1:0]  count_d;

  swc_confirm #(
    .N_WIRE (N_WIRE),
    .N_SCINT(N_SCINT)
  ) u_confirm (
    .wire_hits (wire_hits),
    .scint_hits(scint_hits),
    .confirmed (confirmed)
  );

  swc_centroid #(
    .N_WIRE(N_WIRE)
  ) u_centroid (
    .confirmed(confirmed),
    .centroid (centroid_d)
  );

  swc_scint_count #(
    .N_SCINT(N_SCINT),
    .CNT_W  (CNT_W)
  ) u_count (
    .scint_hits(scint_hits),
    .count     (count_d)
  );

  // Single output register stage; results hold between strobes.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      centroid    <= '0;
      scint_count <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        centroid    <= centroid_d;
        scint_count <= count_d;
      end
    end
  end

endmodule

// File: rtl/scint_wire_centroid_chk.sv
module scint_wire_centroid_chk #(
  parameter int N_WIRE  = 96,
  parameter int N_SCINT = 48,
  parameter int CNT_W   = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [N_WIRE-1:0]   wire_hits,
  input logic [N_SCINT-1:0]  scint_hits,
  input logic                out_valid,
  input logic [2*N_WIRE-1:0] centroid,
  input logic [CNT_W-1:0]    scint_count
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && centroid == '0 && scint_count == '0));

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(centroid) && $stable(scint_count)));

  // R4
  no_wire_no_centroid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wire_hits == '0) |=> centroid == '0);

  // R4
  no_scint_no_centroid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scint_hits == '0) |=> (centroid == '0 && scint_count == '0));

  // R7
  runs_separated_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((centroid & (centroid >> 1)) == '0));

  // R10
  count_saturates_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $countones(scint_hits) >= 3) |=> scint_count == CNT_W'(3));

endmodule

bind scint_wire_centroid scint_wire_centroid_chk #(
  .N_WIRE (N_WIRE),
  .N_SCINT(N_SCINT),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .wire_hits  (wire_hits),
  .scint_hits (scint_hits),
  .out_valid  (out_valid),
  .centroid   (centroid),
  .scint_count(scint_count)
);

// File: tb/scint_wire_centroid_bench.sv
module scint_wire_centroid_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [95:0]  wire_hits = '0;
  logic [47:0]  scint_a = '0;
  logic [95:0]  scint_c = '0;
  logic         ov_a, ov_c;
  logic [191:0] cent_a, cent_c;
  logic [1:0]   cnt_a, cnt_c;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  scint_wire_centroid #(.N_WIRE(96), .N_SCINT(48), .CNT_W(2)) u_scint_wire_centroid (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wire_hits(wire_hits),
    .scint_hits(scint_a), .out_valid(ov_a), .centroid(cent_a), .scint_count(cnt_a));

  scint_wire_centroid #(.N_WIRE(96), .N_SCINT(96), .CNT_W(2)) u_scint_wire_centroid_wide (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wire_hits(wire_hits),
    .scint_hits(scint_c), .out_valid(ov_c), .centroid(cent_c), .scint_count(cnt_c));

  // Expected centroid map from R4..R9: confirm, find runs, mark start+end.
  function automatic logic [191:0] ref_cent(input logic [95:0] w, input logic [95:0] s, input int ns);
    logic [95:0] c;
    logic [191:0] r;
    int i, a;
    r = '0;
    for (int k = 0; k < 96; k++) begin
      int j;
      bit ok;
      j = (k * ns) / 96;
      ok = s[j];
      if (j > 0) ok = ok | s[j-1];
      if (j < ns - 1) ok = ok | s[j+1];
      c[k] = w[k] & ok;
    end
    i = 0;
    while (i < 96) begin
      if (c[i]) begin
        a = i;
        while (i < 96 && c[i]) i++;
        r[a + i - 1] = 1'b1;
      end else begin
        i++;
      end
    end
    return r;
  endfunction

  function automatic int sat3(input logic [95:0] v);
    int n;
    n = $countones(v);
    return (n > 3) ? 3 : n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [95:0] w, input logic [47:0] sa,
                       input logic [95:0] sc, input string req);
    logic [191:0] ea, ec;
    int na, nc;
    ea = ref_cent(w, {48'b0, sa}, 48);
    ec = ref_cent(w, sc, 96);
    na = sat3({48'b0, sa});
    nc = sat3(sc);
    @(negedge clk);
    wire_hits = w; scint_a = sa; scint_c = sc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(ov_a && ov_c, "R2", "out_valid", {190'b0, ov_a, ov_c}, 192'b11);
    chk(cent_a == ea, req, "centroid narrow", cent_a, ea);
    chk(cent_c == ec, {req, "/R11"}, "centroid wide", cent_c, ec);
    chk(int'(cnt_a) == na, "R10", "count narrow", 192'(cnt_a), 192'(na));
    chk(int'(cnt_c) == nc, "R10", "count wide", 192'(cnt_c), 192'(nc));
    wire_hits = ~w; scint_a = ~sa; scint_c = ~sc;
    @(negedge clk);
    chk(!ov_a && cent_a == ea && int'(cnt_a) == na, "R3", "hold narrow", cent_a, ea);
    chk(!ov_c && cent_c == ec && int'(cnt_c) == nc, "R3", "hold wide", cent_c, ec);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [95:0] w;
    logic [47:0] sa;
    logic [95:0] sc;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ov_a && cent_a == '0 && cnt_a == '0, "R1", "reset narrow", cent_a, '0);
    chk(!ov_c && cent_c == '0 && cnt_c == '0, "R1", "reset wide", cent_c, '0);
    rst = 1'b0;

    // R5, R9: every isolated wire with all counters on
    for (int i = 0; i < 96; i++) apply(96'b1 << i, '1, '1, "R5");
    // R6, R9: every adjacent pair
    for (int i = 0; i < 95; i++) apply(96'b11 << i, '1, '1, "R6");
    // R7, R9: runs of length 3..6, including both layer ends
    for (int len = 3; len <= 6; len++) begin
      apply((96'b1 << len) - 96'b1, '1, '1, "R7");
      apply(((96'b1 << len) - 96'b1) << (96 - len), '1, '1, "R7");
      apply(((96'b1 << len) - 96'b1) << 40, '1, '1, "R7");
    end
    apply('1, '1, '1, "R7");
    // R4, R11: single counter at each offset around each wire
    for (int i = 0; i < 96; i++) begin
      for (int d = -2; d <= 2; d++) begin
        int ja, jc;
        ja = (i * 48) / 96 + d;
        jc = i + d;
        sa = (ja >= 0 && ja < 48) ? (48'b1 << ja) : '0;
        sc = (jc >= 0 && jc < 96) ? (96'b1 << jc) : '0;
        apply(96'b1 << i, sa, sc, "R4");
      end
    end
    // R8: unconfirmed wires split a row of hits (wires 14,15 lose cover)
    sa = '1; sa[8:6] = 3'b000;
    sc = '1; sc[16:13] = 4'b0000;
    apply(96'h1FFC00, sa, sc, "R8");
    // R9: edge counters only
    apply(96'b1 | (96'b1 << 95), 48'b1, 96'b1, "R9");
    apply(96'b1 | (96'b1 << 95), 48'b1 << 47, 96'b1 << 95, "R9");
    // R10: counter totals 0..5
    for (int k = 0; k <= 5; k++) apply('0, (48'b1 << k) - 48'b1, (96'b1 << (2 * k)) - 96'b1, "R10");
    // R4..R8: random patterns of mixed density
    for (int n = 0; n < 400; n++) begin
      w  = {$urandom, $urandom, $urandom};
      sa = {$urandom, $urandom};
      sc = {$urandom, $urandom, $urandom};
      if (n % 2 == 0) sa = sa & {$urandom, $urandom} & {$urandom, $urandom};
      if (n % 3 == 0) sc = sc & {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      apply(w, sa, sc, "R8");
    end
    // R1: reset wins over a strobe in the same cycle
    apply('1, '1, '1, "R7");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; wire_hits = '1; scint_a = '1; scint_c = '1;
    @(negedge clk);
    chk(!ov_a && cent_a == '0 && cnt_a == '0, "R1", "reset priority narrow", cent_a, '0);
    chk(!ov_c && cent_c == '0 && cnt_c == '0, "R1", "reset priority wide", cent_c, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule